// File: doc/BRIEF.md
# Polled/Interrupt ADC Channel Controller

This block is a bus-slave peripheral that lets a processor run an external analog-to-digital converter through an analog input multiplexer. Software selects one of 64 analog inputs by writing a channel-select register. That write also starts a conversion.

The controller then waits for the converter's done strobe, latches the 12-bit result into a data register and raises a ready flag. Software can poll the ready flag as the sign bit of the low status byte. It can also set an enable bit, so that a finished conversion raises an interrupt request instead.

Reads of every register are free of side effects. A program can therefore compare the current channel against a limit before it advances to the next one.

Top module: `adc_chan_ctrl`

## Requirements
- R1: After reset, the status, channel and data registers all read as zero, `irq` is low and no conversion is running.
- R2: A bus write to word address 1 (channel register) stores bits [5:0] of the write data. It pulses `conv_start` for exactly one cycle, in the cycle after the write, with `conv_chan` equal to the new channel. The channel register reads back with bits [15:6] zero.
- R3: Reads of any register, including the channel register, never start a conversion.
- R4: A channel write clears ready (status bit 7) in the next cycle. When `conv_done` is seen during a running conversion, ready is set and the data register (word address 2) shows `conv_result` zero-extended to 16 bits, both from the following cycle.
- R5: The status register (word address 0) holds interrupt enable in bit 6, which is read/write, and ready in bit 7, which is read-only. All its other bits read as zero.
- R6: `irq` is high exactly when ready and interrupt enable are both set, and it drops in the cycle in which a channel write clears ready.
- R7: A channel write during a running conversion aborts it and starts a new conversion on the new channel. Ready stays low until that new conversion completes.
- R8: A `conv_done` strobe that arrives while no conversion is running changes neither ready nor the data register.
- R9: Writes to the data register are ignored.
- R10: All 64 channels, 0 through 63, are reachable. A written value above 63 selects the channel given by its low six bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Peripheral selected for a bus access |
| bus_wr | input | 1 | Access is a write (with bus_sel) |
| bus_addr | input | 2 | Word address: 0 status, 1 channel, 2 data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, zero when not selected |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 6 | Channel select driven to the analog multiplexer |
| conv_done | input | 1 | Converter completion strobe |
| conv_result | input | 12 | Converter result, valid with conv_done |

## Verification
The assertions check four things on every cycle:
- each channel write is followed by a start pulse, and no start pulse appears without one;
- ready falls after every channel write and rises only after a done strobe that arrived during a running conversion;
- a stray done leaves the data register and ready untouched;
- `irq` never stays high once ready has fallen.

Only the bench scenarios can show the rest:
- the result values that are latched, and their zero extension;
- the read-back encodings of the status and channel registers;
- the wrap of channel values above 63;
- the outcome of an aborted conversion;
- the order of the channels sent to the converter, which the scoreboard compares.

// File: rtl/adc_chan_ctrl.sv
module adc_chan_ctrl #(
  parameter int CHAN_W = 6,
  parameter int RES_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result
);
  localparam int RDY_BIT = 7;
  localparam int IE_BIT  = 6;
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_CHAN = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic              rdy_q, ie_q, busy_q, start_q;
  logic [CHAN_W-1:0] chan_q;
  logic [RES_W-1:0]  data_q;
  logic              chan_wr, stat_wr, finish;

  assign chan_wr = bus_sel && bus_wr && bus_addr == A_CHAN;
  assign stat_wr = bus_sel && bus_wr && bus_addr == A_STAT;
  assign finish  = busy_q && conv_done && !chan_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      ie_q    <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      chan_q  <= '0;
      data_q  <= '0;
    end else begin
      start_q <= chan_wr;
      if (stat_wr) ie_q <= bus_wdata[IE_BIT];
      if (chan_wr) begin
        chan_q <= bus_wdata[CHAN_W-1:0];
        rdy_q  <= 1'b0;
        busy_q <= 1'b1;
      end else if (finish) begin
        data_q <= conv_result;
        rdy_q  <= 1'b1;
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        A_STAT: begin
          bus_rdata[RDY_BIT] = rdy_q;
          bus_rdata[IE_BIT]  = ie_q;
        end
        A_CHAN:  bus_rdata[CHAN_W-1:0] = chan_q;
        A_DATA:  bus_rdata[RES_W-1:0]  = data_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq        = rdy_q & ie_q;
  assign conv_start = start_q;
  assign conv_chan  = chan_q;

  // R2
  start_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_wr |=> conv_start);
  // R3
  start_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(bus_sel && bus_wr && bus_addr == A_CHAN));
  // R4
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_wr |=> !rdy_q);
  // R4
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $past(conv_done && busy_q));
  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_q) |-> !irq);
  // R8
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !busy_q && !chan_wr) |=> $stable(data_q) && $stable(rdy_q));
endmodule

// File: tb/adc_chan_ctrl_test.sv
module adc_chan_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, conv_start;
  logic [5:0]  conv_chan;
  logic        conv_done;
  logic [11:0] conv_result;

  logic        mdl_done = 1'b0, stray = 1'b0;
  logic [11:0] mdl_res = '0, stray_res = '0;
  logic [5:0]  mdl_ch = '0;
  int          mdl_cnt = 0;
  int          errors = 0, checks = 0;
  logic [5:0]  exp_q[$];

  assign conv_done   = mdl_done | stray;
  assign conv_result = stray ? stray_res : mdl_res;

  always #5 clk = ~clk;

  adc_chan_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result)
  );

  function automatic logic [11:0] res_of(input logic [5:0] ch);
    return 12'((int'(ch) * 61 + 291) % 4096);
  endfunction

  // converter model: restarts on each start pulse, done after 6 cycles
  always @(posedge clk) begin
    mdl_done <= 1'b0;
    if (conv_start) begin
      mdl_ch  <= conv_chan;
      mdl_cnt <= 6;
    end else if (mdl_cnt > 0) begin
      mdl_cnt <= mdl_cnt - 1;
      if (mdl_cnt == 1) begin
        mdl_done <= 1'b1;
        mdl_res  <= res_of(mdl_ch);
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each start pulse must match the next queued channel
  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      if (exp_q.size() == 0) check("R3 unexpected start", 16'(conv_chan), 16'hFFFF);
      else check("R2 start channel", 16'(conv_chan), 16'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 2'd1) exp_q.push_back(d[5:0]);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_ready();
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 50 && !s[7]; i++) rd(2'd0, s);
    check("R4 ready reached", 16'(s[7]), 16'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R1 status", v, 16'h0000);
    rd(2'd1, v); check("R1 channel", v, 16'h0000);
    rd(2'd2, v); check("R1 data", v, 16'h0000);
    check("R1 irq", 16'(irq), 16'd0);

    wr(2'd1, 16'h0005);
    rd(2'd0, v); check("R4 ready low while busy", v, 16'h0000);
    rd(2'd1, v); check("R2 channel readback", v, 16'h0005);
    wait_ready();
    rd(2'd2, v); check("R4 data", v, 16'(res_of(6'd5)));

    for (int i = 0; i < 20; i++) rd(2'(i % 3), v);
    check("R3 no pending starts", 16'(exp_q.size()), 16'd0);
    rd(2'd0, v); check("R3 ready kept after reads", v, 16'h0080);

    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); check("R5 status bits", v, 16'h00C0);
    check("R6 irq set", 16'(irq), 16'd1);

    wr(2'd1, 16'h003F);
    check("R6 irq drops", 16'(irq), 16'd0);
    rd(2'd0, v); check("R4 ready cleared", v, 16'h0040);
    wait_ready();
    rd(2'd2, v); check("R10 last channel data", v, 16'(res_of(6'd63)));
    check("R6 irq on completion", 16'(irq), 16'd1);

    wr(2'd1, 16'h0047);
    rd(2'd1, v); check("R10 channel wrap", v, 16'h0007);
    wait_ready();
    rd(2'd2, v); check("R10 wrapped data", v, 16'(res_of(6'd7)));

    wr(2'd1, 16'd10);
    @(negedge clk); @(negedge clk);
    wr(2'd1, 16'd20);
    repeat (5) @(negedge clk);
    rd(2'd0, v); check("R7 ready low after abort", 16'(v[7]), 16'd0);
    wait_ready();
    rd(2'd2, v); check("R7 data of new channel", v, 16'(res_of(6'd20)));

    stray_res = 12'hABC; stray = 1'b1;
    @(negedge clk); stray = 1'b0;
    @(negedge clk);
    rd(2'd2, v); check("R8 stray done ignored", v, 16'(res_of(6'd20)));
    rd(2'd0, v); check("R8 ready unchanged", v, 16'h00C0);

    wr(2'd2, 16'hFFFF);
    rd(2'd2, v); check("R9 data write ignored", v, 16'(res_of(6'd20)));

    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R5 enable cleared", v, 16'h0080);
    check("R6 irq off", 16'(irq), 16'd0);
    check("R2 all starts seen", 16'(exp_q.size()), 16'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule